// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor datapath in which one ALU and one memory are shared across the steps of each instruction. It is a finite state machine. Every state drives the full set of datapath strobes and mux selects. The next state is chosen from the current state, the opcode, the function field and the ALU overflow flag.

The supported instructions are the register-register operations add, sub, and, or and set-less-than, together with word load, word store, branch-if-equal and jump. The number of cycles depends on the instruction class. The datapath holds the fetched instruction word steady from the second state onward, so the opcode and function inputs are only consulted from that point.

Two faults leave the normal path and pass through a single exception state:
- an opcode outside the supported set;
- a signed overflow on add or sub.

The exception state records the return address and the cause, and sends the program counter to the exception entry point.

Top module: `mcf_ctrl_top`

## Requirements
- R1: While `rst_n` is low, every output is 0, and reset is sampled synchronously. The first cycle after `rst_n` rises is a fetch cycle. This also holds when reset arrives in the middle of an instruction.
- R2: In a fetch cycle the outputs are `mem_read`=1, `ir_write`=1, `iord`=0, `alu_src_a`=0 (PC), `alu_src_b`=1 (constant 4), `alu_ctl`=3'b010 (add), `pc_write`=1 and `pc_src`=0 (ALU result). No other output is active.
- R3: The second cycle of every instruction is a decode cycle with `alu_src_a`=0, `alu_src_b`=3 (sign-extended immediate shifted left by 2) and `alu_ctl`=add. No strobe is active in this cycle.
- R4: A load (opcode 0x23) takes 5 cycles. After fetch and decode come: an address cycle (`alu_src_a`=1, `alu_src_b`=2 sign-extended immediate, add); a read cycle (`mem_read`=1, `iord`=1); and a writeback cycle (`reg_write`=1, `reg_dst`=0, `mem_to_reg`=1).
- R5: A store (opcode 0x2B) takes 4 cycles. The third cycle is the same address cycle used by a load. The fourth cycle has `mem_write`=1 and `iord`=1.
- R6: An R-type instruction (opcode 0x00) takes 4 cycles: an execute cycle (`alu_src_a`=1, `alu_src_b`=0) followed by a writeback cycle (`reg_write`=1, `reg_dst`=1). In the execute cycle, `alu_ctl` comes from the function field:
  - 0x20 gives add (010);
  - 0x22 gives sub (110);
  - 0x24 gives and (000);
  - 0x25 gives or (001);
  - 0x2A gives set-less-than (111);
  - any other value gives add.
- R7: A branch-if-equal (opcode 0x04) takes 3 cycles. The third cycle has `alu_src_a`=1, `alu_src_b`=0, `alu_ctl`=sub, `pc_write_cond`=1 and `pc_src`=1 (saved target).
- R8: A jump (opcode 0x02) takes 3 cycles. The third cycle has `pc_write`=1 and `pc_src`=2 (jump target).
- R9: Any other opcode goes from decode straight to the exception cycle, so the instruction takes 3 cycles. The exception cycle has `epc_write`=1, `cause_write`=1, `int_cause`=0, `pc_write`=1, `pc_src`=3 (exception vector), `alu_src_a`=0, `alu_src_b`=1 and `alu_ctl`=sub, so the ALU presents PC−4.
- R10: If `alu_ovf` is high in the execute cycle of an add or sub, the writeback cycle is replaced by the exception cycle with `int_cause`=1. The instruction still takes 4 cycles, and no register write happens.
- R11: `alu_ovf` has no effect in any other cycle, and has no effect for and, or and set-less-than.
- R12: Any output not named for a cycle above is 0 in that cycle. After the last cycle of each instruction, the next cycle is a fetch. `pc_write` and `pc_write_cond` are never both high, and a memory strobe never coincides with `reg_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction word |
| funct | input | 6 | Function field of the held instruction word |
| alu_ovf | input | 1 | Signed overflow flag from the ALU |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| iord | output | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| ir_write | output | 1 | Instruction register load |
| reg_write | output | 1 | Register file write strobe |
| reg_dst | output | 1 | Destination register field: 0 = bits 20:16, 1 = bits 15:11 |
| mem_to_reg | output | 1 | Register write data: 0 = ALU output register, 1 = memory data register |
| alu_src_a | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU operand B: 0 = register B, 1 = 4, 2 = sign-extended immediate, 3 = that value shifted left by 2 |
| alu_ctl | output | 3 | ALU operation code |
| pc_write | output | 1 | Unconditional PC write |
| pc_write_cond | output | 1 | PC write, gated by ALU zero in the datapath |
| pc_src | output | 2 | PC source: 0 = ALU, 1 = ALU output register, 2 = jump target, 3 = exception vector |
| epc_write | output | 1 | Exception return-address register write |
| cause_write | output | 1 | Cause register write |
| int_cause | output | 1 | Cause value: 0 = undefined opcode, 1 = overflow |

## Verification
Two of the block's functions can fall in the same cycle: the overflow check and the writeback decision for R-type instructions. Both are settled in the single execute cycle. To provoke this, every function code is swept with `alu_ovf` both low and high. Add and sub with the flag high must give the exception cycle with cause 1. The other codes must still reach the normal writeback, with no epc or cause strobe.

The flag is also held high for the whole of every non-R-type opcode. This shows it cannot leak into the address, branch or fetch cycles, which also use the ALU. Finally, reset is asserted partway through a load, and the next cycle is checked to be a clean fetch.

// File: rtl/mcf_pkg.sv
// Package: shared state, class and control-word types for the multicycle
// control sequencer. Assumes a 6-bit opcode and function field.
package mcf_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWR, S_LDWB,
        S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_EXC
    } state_t;

    typedef enum logic [2:0] {
        C_RTYPE, C_LOAD, C_STORE, C_BEQ, C_JUMP, C_UNDEF
    } op_class_t;

    localparam logic [2:0] ALU_AND = 3'b000;
    localparam logic [2:0] ALU_OR  = 3'b001;
    localparam logic [2:0] ALU_ADD = 3'b010;
    localparam logic [2:0] ALU_SUB = 3'b110;
    localparam logic [2:0] ALU_SLT = 3'b111;

    typedef struct packed {
        logic       mem_read;
        logic       mem_write;
        logic       iord;
        logic       ir_write;
        logic       reg_write;
        logic       reg_dst;
        logic       mem_to_reg;
        logic       alu_src_a;
        logic [1:0] alu_src_b;
        logic [2:0] alu_ctl;
        logic       pc_write;
        logic       pc_write_cond;
        logic [1:0] pc_src;
        logic       epc_write;
        logic       cause_write;
        logic       int_cause;
    } ctrl_t;

endpackage

// File: rtl/mcf_decode.sv
// Module: mcf_decode
// Classifies the held opcode and maps the function field to an ALU code.
// Also flags the functions whose overflow must trap (add, sub).
// Assumes the opcode and function inputs are stable from decode onward.
module mcf_decode #(
    parameter int          OP_W     = 6,
    parameter int          FN_W     = 6,
    parameter logic [5:0]  OP_RTYPE = 6'h00,
    parameter logic [5:0]  OP_JUMP  = 6'h02,
    parameter logic [5:0]  OP_BEQ   = 6'h04,
    parameter logic [5:0]  OP_LOAD  = 6'h23,
    parameter logic [5:0]  OP_STORE = 6'h2B
) (
    input  logic [OP_W-1:0]          opcode,
    input  logic [FN_W-1:0]          funct,
    output mcf_pkg::op_class_t       op_class,
    output logic [2:0]               alu_fn,
    output logic                     ovf_chk
);
    import mcf_pkg::*;

    // Opcode to instruction class; everything unlisted is undefined.
    always_comb begin
        if      (opcode == OP_W'(OP_RTYPE)) op_class = C_RTYPE;
        else if (opcode == OP_W'(OP_LOAD))  op_class = C_LOAD;
        else if (opcode == OP_W'(OP_STORE)) op_class = C_STORE;
        else if (opcode == OP_W'(OP_BEQ))   op_class = C_BEQ;
        else if (opcode == OP_W'(OP_JUMP))  op_class = C_JUMP;
        else                                op_class = C_UNDEF;
    end

    // Function field to ALU operation plus overflow-check flag.
    always_comb begin
        ovf_chk = 1'b0;
        case (funct)
            FN_W'(6'h20): begin alu_fn = ALU_ADD; ovf_chk = 1'b1; end
            FN_W'(6'h22): begin alu_fn = ALU_SUB; ovf_chk = 1'b1; end
            FN_W'(6'h24): alu_fn = ALU_AND;
            FN_W'(6'h25): alu_fn = ALU_OR;
            FN_W'(6'h2A): alu_fn = ALU_SLT;
            default:      alu_fn = ALU_ADD;
        endcase
    end
endmodule

// File: rtl/mcf_next.sv
// Module: mcf_next
// State register and next-state choice. Also latches the exception cause
// on the way into the exception state. Synchronous active-low reset.
module mcf_next (
    input  logic                clk,
    input  logic                rst_n,
    input  mcf_pkg::op_class_t  op_class,
    input  logic                ovf_chk,
    input  logic                alu_ovf,
    output mcf_pkg::state_t     state,
    output logic                exc_ovf
);
    import mcf_pkg::*;

    state_t nxt;

    // Next state from current state, class and overflow.
    always_comb begin
        case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                case (op_class)
                    C_RTYPE:          nxt = S_REXEC;
                    C_LOAD, C_STORE:  nxt = S_MEMADR;
                    C_BEQ:            nxt = S_BRANCH;
                    C_JUMP:           nxt = S_JUMP;
                    default:          nxt = S_EXC;
                endcase
            end
            S_MEMADR: nxt = (op_class == C_LOAD) ? S_MEMRD : S_MEMWR;
            S_MEMRD:  nxt = S_LDWB;
            S_REXEC:  nxt = (ovf_chk && alu_ovf) ? S_EXC : S_RWB;
            default:  nxt = S_FETCH;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= nxt;
    end

    // Cause latch: cleared in decode, set by a trapping overflow in execute.
    always_ff @(posedge clk) begin
        if (!rst_n)                 exc_ovf <= 1'b0;
        else if (state == S_DECODE) exc_ovf <= 1'b0;
        else if (state == S_REXEC)  exc_ovf <= ovf_chk && alu_ovf;
    end

    assert_fetch_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> state == S_FETCH);
    assert_load_read_then_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_MEMRD |=> state == S_LDWB);
    assert_undef_traps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && op_class == C_UNDEF) |=> (state == S_EXC && !exc_ovf));
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REXEC && ovf_chk && alu_ovf) |=> (state == S_EXC && exc_ovf));
    assert_ovf_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_REXEC && !ovf_chk) |=> state == S_RWB);
    assert_back_to_fetch_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {S_LDWB, S_MEMWR, S_RWB, S_BRANCH, S_JUMP, S_EXC}) |=> state == S_FETCH);
endmodule

// File: rtl/mcf_outputs.sv
// Module: mcf_outputs
// Control word for each state. Every field not named for a state is 0.
// The whole word is forced to 0 while reset is low.
module mcf_outputs (
    input  logic             rst_n,
    input  mcf_pkg::state_t  state,
    input  logic [2:0]       alu_fn,
    input  logic             exc_ovf,
    output mcf_pkg::ctrl_t   ctrl
);
    import mcf_pkg::*;

    ctrl_t c;

    // Per-state control word.
    always_comb begin
        c = '0;
        case (state)
            S_FETCH: begin
                c.mem_read = 1'b1; c.ir_write = 1'b1;
                c.alu_src_b = 2'd1; c.alu_ctl = ALU_ADD;
                c.pc_write = 1'b1; c.pc_src = 2'd0;
            end
            S_DECODE: begin
                c.alu_src_b = 2'd3; c.alu_ctl = ALU_ADD;
            end
            S_MEMADR: begin
                c.alu_src_a = 1'b1; c.alu_src_b = 2'd2; c.alu_ctl = ALU_ADD;
            end
            S_MEMRD:  begin c.mem_read = 1'b1;  c.iord = 1'b1; end
            S_MEMWR:  begin c.mem_write = 1'b1; c.iord = 1'b1; end
            S_LDWB:   begin c.reg_write = 1'b1; c.mem_to_reg = 1'b1; end
            S_REXEC:  begin c.alu_src_a = 1'b1; c.alu_ctl = alu_fn; end
            S_RWB:    begin c.reg_write = 1'b1; c.reg_dst = 1'b1; end
            S_BRANCH: begin
                c.alu_src_a = 1'b1; c.alu_ctl = ALU_SUB;
                c.pc_write_cond = 1'b1; c.pc_src = 2'd1;
            end
            S_JUMP:   begin c.pc_write = 1'b1; c.pc_src = 2'd2; end
            S_EXC: begin
                c.alu_src_b = 2'd1; c.alu_ctl = ALU_SUB;
                c.epc_write = 1'b1; c.cause_write = 1'b1; c.int_cause = exc_ovf;
                c.pc_write = 1'b1; c.pc_src = 2'd3;
            end
            default: c = '0;
        endcase
    end

    // Reset gating of the whole word.
    always_comb ctrl = rst_n ? c : '0;
endmodule

// File: rtl/mcf_ctrl_top.sv
// Module: mcf_ctrl_top
// Control sequencer for a shared-ALU, shared-memory multicycle datapath.
// Assumes the datapath holds the instruction word from decode until the
// next fetch, and gates pc_write_cond with its own ALU zero flag.
module mcf_ctrl_top #(
    parameter int OP_W = 6,
    parameter int FN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  opcode,
    input  logic [FN_W-1:0]  funct,
    input  logic             alu_ovf,
    output logic             mem_read,
    output logic             mem_write,
    output logic             iord,
    output logic             ir_write,
    output logic             reg_write,
    output logic             reg_dst,
    output logic             mem_to_reg,
    output logic             alu_src_a,
    output logic [1:0]       alu_src_b,
    output logic [2:0]       alu_ctl,
    output logic             pc_write,
    output logic             pc_write_cond,
    output logic [1:0]       pc_src,
    output logic             epc_write,
    output logic             cause_write,
    output logic             int_cause
);
    import mcf_pkg::*;

    op_class_t  op_class;
    logic [2:0] alu_fn;
    logic       ovf_chk;
    state_t     state;
    logic       exc_ovf;
    ctrl_t      ctrl;

    mcf_decode #(.OP_W(OP_W), .FN_W(FN_W)) u_dec (
        .opcode(opcode), .funct(funct),
        .op_class(op_class), .alu_fn(alu_fn), .ovf_chk(ovf_chk)
    );

    mcf_next u_nxt (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .ovf_chk(ovf_chk),
        .alu_ovf(alu_ovf), .state(state), .exc_ovf(exc_ovf)
    );

    mcf_outputs u_out (
        .rst_n(rst_n), .state(state), .alu_fn(alu_fn), .exc_ovf(exc_ovf), .ctrl(ctrl)
    );

    // Unpack the control word onto the ports.
    always_comb begin
        mem_read      = ctrl.mem_read;
        mem_write     = ctrl.mem_write;
        iord          = ctrl.iord;
        ir_write      = ctrl.ir_write;
        reg_write     = ctrl.reg_write;
        reg_dst       = ctrl.reg_dst;
        mem_to_reg    = ctrl.mem_to_reg;
        alu_src_a     = ctrl.alu_src_a;
        alu_src_b     = ctrl.alu_src_b;
        alu_ctl       = ctrl.alu_ctl;
        pc_write      = ctrl.pc_write;
        pc_write_cond = ctrl.pc_write_cond;
        pc_src        = ctrl.pc_src;
        epc_write     = ctrl.epc_write;
        cause_write   = ctrl.cause_write;
        int_cause     = ctrl.int_cause;
    end

    assert_pc_writes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pc_write && pc_write_cond));
    assert_one_resource_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !((mem_read || mem_write) && reg_write));
    assert_no_regwrite_on_trap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        epc_write |-> (!reg_write && cause_write));
endmodule

// File: tb/tb_mcf_ctrl_top.sv
// Bench: sweeps every opcode, every listed function code plus an unlisted
// one, and the overflow flag both ways. Checks the control word every cycle
// against a sequence rebuilt from the requirements.
module tb_mcf_ctrl_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic alu_ovf = 1'b0;
    logic mem_read, mem_write, iord, ir_write, reg_write, reg_dst, mem_to_reg, alu_src_a;
    logic [1:0] alu_src_b, pc_src;
    logic [2:0] alu_ctl;
    logic pc_write, pc_write_cond, epc_write, cause_write, int_cause;

    int n_tests = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    mcf_ctrl_top dut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_ovf(alu_ovf),
        .mem_read(mem_read), .mem_write(mem_write), .iord(iord), .ir_write(ir_write),
        .reg_write(reg_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_ctl(alu_ctl),
        .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_src(pc_src),
        .epc_write(epc_write), .cause_write(cause_write), .int_cause(int_cause)
    );

    wire [19:0] got = {mem_read, mem_write, iord, ir_write, reg_write, reg_dst, mem_to_reg,
                       alu_src_a, alu_src_b, alu_ctl, pc_write, pc_write_cond, pc_src,
                       epc_write, cause_write, int_cause};

    // Phase codes used by the bench model.
    localparam int P_F = 0, P_D = 1, P_MA = 2, P_MR = 3, P_MW = 4, P_LW = 5,
                   P_RX = 6, P_RW = 7, P_BR = 8, P_J = 9, P_X = 10, P_END = -1;

    function automatic logic [2:0] alu_of(input logic [5:0] fn);
        case (fn)
            6'h20: return 3'b010;
            6'h22: return 3'b110;
            6'h24: return 3'b000;
            6'h25: return 3'b001;
            6'h2A: return 3'b111;
            default: return 3'b010;
        endcase
    endfunction

    // Expected control word per phase, built field by field from R2..R10.
    function automatic logic [19:0] exp_word(input int ph, input logic [5:0] fn, input logic cause);
        logic mr, mw, io, irw, rw, rd, m2r, sa, pw, pwc, ew, cw, ic;
        logic [1:0] sb, ps;
        logic [2:0] ac;
        {mr, mw, io, irw, rw, rd, m2r, sa, pw, pwc, ew, cw, ic} = '0;
        sb = 2'd0; ps = 2'd0; ac = 3'b000;
        case (ph)
            P_F:  begin mr = 1; irw = 1; sb = 2'd1; ac = 3'b010; pw = 1; ps = 2'd0; end
            P_D:  begin sb = 2'd3; ac = 3'b010; end
            P_MA: begin sa = 1; sb = 2'd2; ac = 3'b010; end
            P_MR: begin mr = 1; io = 1; end
            P_MW: begin mw = 1; io = 1; end
            P_LW: begin rw = 1; m2r = 1; end
            P_RX: begin sa = 1; ac = alu_of(fn); end
            P_RW: begin rw = 1; rd = 1; end
            P_BR: begin sa = 1; ac = 3'b110; pwc = 1; ps = 2'd1; end
            P_J:  begin pw = 1; ps = 2'd2; end
            P_X:  begin sb = 2'd1; ac = 3'b110; ew = 1; cw = 1; ic = cause; pw = 1; ps = 2'd3; end
            default: ;
        endcase
        return {mr, mw, io, irw, rw, rd, m2r, sa, sb, ac, pw, pwc, ps, ew, cw, ic};
    endfunction

    // Expected phase k of an instruction, P_END past its last cycle.
    function automatic int phase_at(input logic [5:0] op, input logic [5:0] fn,
                                    input logic ov, input int k);
        logic trap;
        trap = ov && (fn == 6'h20 || fn == 6'h22);
        if (k == 0) return P_F;
        if (k == 1) return P_D;
        case (op)
            6'h00: return (k == 2) ? P_RX : (k == 3) ? (trap ? P_X : P_RW) : P_END;
            6'h23: return (k == 2) ? P_MA : (k == 3) ? P_MR : (k == 4) ? P_LW : P_END;
            6'h2B: return (k == 2) ? P_MA : (k == 3) ? P_MW : P_END;
            6'h04: return (k == 2) ? P_BR : P_END;
            6'h02: return (k == 2) ? P_J : P_END;
            default: return (k == 2) ? P_X : P_END;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic [5:0] fn,
                                     input logic ov, input int k);
        if (k == 0) return "R2";
        if (k == 1) return "R3";
        case (op)
            6'h00: return (ov && (fn == 6'h20 || fn == 6'h22)) ? "R10" : (ov ? "R11" : "R6");
            6'h23: return ov ? "R11/R4" : "R4";
            6'h2B: return ov ? "R11/R5" : "R5";
            6'h04: return "R7";
            6'h02: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input logic [19:0] act, input logic [19:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %05h expected %05h (op=%02h fn=%02h ovf=%0b)",
                     req, act, expv, opcode, funct, alu_ovf);
        end
    endtask

    // Run one instruction from its fetch cycle; called at a negedge.
    task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic ov);
        logic cause;
        opcode = op; funct = fn; alu_ovf = ov;
        cause = (op == 6'h00) && ov && (fn == 6'h20 || fn == 6'h22);
        for (int k = 0; phase_at(op, fn, ov, k) != P_END; k++) begin
            #1;
            check(req_of(op, fn, ov, k), got, exp_word(phase_at(op, fn, ov, k), fn, cause));
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [5:0] fns [6];
        fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h00};
        // R1: outputs quiet during reset.
        opcode = 6'h23;
        repeat (3) begin
            @(negedge clk); #1;
            check("R1", got, 20'h0);
        end
        rst_n = 1'b1;
        // R6, R10, R11: every function code with overflow low and high.
        foreach (fns[i])
            for (int ov = 0; ov < 2; ov++)
                run_instr(6'h00, fns[i], ov[0]);
        // R4, R5, R7, R8, R9, R11: every opcode, overflow low then high.
        for (int ov = 0; ov < 2; ov++)
            for (int op = 1; op < 64; op++)
                run_instr(6'(op), 6'h20, ov[0]);
        // R1: reset in the middle of a load, then a clean fetch.
        opcode = 6'h23; funct = 6'h20; alu_ovf = 1'b0;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        rst_n = 1'b0; #1;
        check("R1", got, 20'h0);
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        run_instr(6'h23, 6'h20, 1'b0);
        run_instr(6'h04, 6'h00, 1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule